// File: doc/BRIEF.md
# Decimated Feedback Reverb Engine

This block adds a room-like echo to a stream of 8-bit audio samples. Each sample comes with a one-cycle strobe. The echo store is a circular buffer. The buffer moves forward only on every eighth accepted sample, so a modest buffer still gives an audible delay. On such an update step the engine does four things in order:

- It reads the oldest entry, which sits one slot past the write position.
- It scales that entry by a fixed-point feedback gain of about 0.8.
- It adds the held input sample and writes the sum back at the new write position.
- It scales the old entry again by about 0.9 and passes it to a short moving-average smoother.

Every other accepted sample is sent straight out with the latest smoothed echo added to it, and an output strobe comes with it.

The control sequencer runs the update step as a fixed chain of states. The smoother is started and then polled for completion before the engine goes idle again. While the chain runs, the engine ignores incoming strobes.

Top module: `decim_reverb`

## Requirements
- R1: A synchronous active-high reset clears the strobe counter, write offset, sequencer, output register, buffer contents and smoother history, so sampleOut is 0 and outValid is low after reset.
- R2: Among strobes accepted while idle, every DECIM-th one is an update strobe: the 8th, the 16th and so on, with DECIM = 8 by default. An update strobe produces no outValid. Every other accepted strobe raises outValid for exactly one cycle, starting in the cycle after the strobe's clock edge.
- R3: An update strobe advances the write offset by one and wraps it from DEPTH-1 to 0. The delayed tap is then read from the entry at the new offset plus one, with wrap.
- R4: The entry written at the new offset is min(255, heldSample + floor(tap*819/1024)), where heldSample is the input value on the update strobe.
- R5: The smoother input is floor(tap*922/1024). After each update, the smoother output is floor(sum of its last 4 inputs / 4); inputs before the first update count as 0.
- R6: For a non-update strobe, sampleOut = sampleIn + the current smoother output, when that sum does not exceed 255.
- R7: When sampleIn plus the smoother output exceeds 255, sampleOut is 255. The output never wraps.
- R8: A strobe that arrives while the update chain is running is dropped: it does not advance the counter and produces no outValid.
- R9: After an update strobe the engine is idle again within LPF_TAPS + 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | One-cycle strobe marking a new input sample |
| sampleIn | input | DATA_W | Input audio sample, unsigned |
| outValid | output | 1 | One-cycle strobe marking a new output sample |
| sampleOut | output | DATA_W | Output sample: live input plus smoothed echo, saturated |

## Verification
The bench builds the engine with DEPTH = 8 and DECIM = 4 and keeps the gains and the 4-tap smoother at their defaults. With these values the write offset wraps many times in a few hundred samples. Non-zero echoes, feedback accumulation in the buffer and output saturation then all appear within a short run. At the default depth of 1024, the first echo would only come back after more than 8000 samples. A strobe placed inside the update chain checks the drop rule, and a reset in the middle of the run shows that buffer and smoother history start again from zero.

// File: rtl/rvb_pkg.sv
package rvb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECAY,
    ST_MIX,
    ST_START,
    ST_WAIT
  } rvbState_e;

  // Strobes from the sequencer to the datapath, one-hot in time.
  typedef struct packed {
    logic latch;      // update strobe accepted: advance offset, hold sample
    logic decay;      // read tap, form feedback term
    logic mix;        // write mixed value, form smoother input
    logic filtStart;  // kick the smoother
    logic emit;       // pass-through strobe accepted: produce output
  } rvbCtl_t;

endpackage

// File: rtl/rvb_ctrl.sv
module rvb_ctrl
  import rvb_pkg::*;
#(
  parameter int DECIM = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleValid,
  input  logic    filtDone,
  output rvbCtl_t ctl,
  output logic    busy
);

  localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;

  rvbState_e state;
  logic [CNT_W-1:0] strobeCnt;
  logic lastSlot;

  assign lastSlot = (strobeCnt == CNT_W'(DECIM - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE: begin
        if (sampleValid) begin
          if (lastSlot) ctl.latch = 1'b1;
          else          ctl.emit  = 1'b1;
        end
      end
      ST_DECAY: ctl.decay     = 1'b1;
      ST_MIX:   ctl.mix       = 1'b1;
      ST_START: ctl.filtStart = 1'b1;
      default:  ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      strobeCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sampleValid) begin
            if (lastSlot) begin
              strobeCnt <= '0;
              state     <= ST_DECAY;
            end else begin
              strobeCnt <= strobeCnt + 1'b1;
            end
          end
        end
        ST_DECAY: state <= ST_MIX;
        ST_MIX:   state <= ST_START;
        ST_START: state <= ST_WAIT;
        ST_WAIT:  if (filtDone) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rvb_lpf.sv
module rvb_lpf #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              done
);

  localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int ACC_W = DATA_W + IDX_W;

  logic [DATA_W-1:0] hist [TAPS];
  logic [ACC_W-1:0]  acc;
  logic [IDX_W-1:0]  idx;
  logic              running;
  logic              finishing;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
      acc       <= '0;
      idx       <= '0;
      running   <= 1'b0;
      finishing <= 1'b0;
      done      <= 1'b0;
      dout      <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        for (int i = TAPS - 1; i > 0; i--) hist[i] <= hist[i-1];
        hist[0] <= din;
        acc     <= '0;
        idx     <= '0;
        running <= 1'b1;
      end else if (running) begin
        acc <= acc + ACC_W'(hist[idx]);
        if (idx == IDX_W'(TAPS - 1)) begin
          running   <= 1'b0;
          finishing <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (finishing) begin
        finishing <= 1'b0;
        done      <= 1'b1;
        dout      <= DATA_W'(acc / ACC_W'(TAPS));
      end
    end
  end

endmodule

// File: rtl/rvb_dp.sv
module rvb_dp
  import rvb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 1024,
  parameter int FB_GAIN   = 819,
  parameter int OUT_GAIN  = 922,
  parameter int GAIN_FRAC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  rvbCtl_t           ctl,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] lpfOut,
  output logic [DATA_W-1:0] filtIn,
  output logic [DATA_W-1:0] sampleOut,
  output logic              outValid
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PROD_W = DATA_W + GAIN_FRAC;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrOff;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] tap;
  logic [DATA_W-1:0] heldSample;
  logic [DATA_W-1:0] tapHold;
  logic [DATA_W-1:0] fbTerm;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] satAdd(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DATA_W] ? {DATA_W{1'b1}} : s[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] gainMul(input logic [DATA_W-1:0] x,
                                                 input int g);
    logic [PROD_W-1:0] p;
    p = PROD_W'(x) * PROD_W'(g);
    return p[GAIN_FRAC +: DATA_W];
  endfunction

  assign rdAddr = stepAddr(wrOff);
  assign tap    = mem[rdAddr];

  // Circular echo store
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.mix) begin
      mem[wrOff] <= satAdd(heldSample, fbTerm);
    end
  end

  // Update-step pipeline registers
  always_ff @(posedge clk) begin
    if (rst) begin
      wrOff      <= '0;
      heldSample <= '0;
      tapHold    <= '0;
      fbTerm     <= '0;
      filtIn     <= '0;
    end else begin
      if (ctl.latch) begin
        wrOff      <= stepAddr(wrOff);
        heldSample <= sampleIn;
      end
      if (ctl.decay) begin
        tapHold <= tap;
        fbTerm  <= gainMul(tap, FB_GAIN);
      end
      if (ctl.mix) filtIn <= gainMul(tapHold, OUT_GAIN);
    end
  end

  // Output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      sampleOut <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) sampleOut <= satAdd(sampleIn, lpfOut);
    end
  end

endmodule

// File: rtl/decim_reverb.sv
module decim_reverb
  import rvb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 1024,
  parameter int DECIM     = 8,
  parameter int FB_GAIN   = 819,
  parameter int OUT_GAIN  = 922,
  parameter int GAIN_FRAC = 10,
  parameter int LPF_TAPS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              outValid,
  output logic [DATA_W-1:0] sampleOut
);

  rvbCtl_t           ctl;
  logic              busy;
  logic              filtDone;
  logic [DATA_W-1:0] filtIn;
  logic [DATA_W-1:0] lpfOut;

  rvb_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .filtDone    (filtDone),
    .ctl         (ctl),
    .busy        (busy)
  );

  rvb_dp #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .FB_GAIN   (FB_GAIN),
    .OUT_GAIN  (OUT_GAIN),
    .GAIN_FRAC (GAIN_FRAC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .sampleIn  (sampleIn),
    .lpfOut    (lpfOut),
    .filtIn    (filtIn),
    .sampleOut (sampleOut),
    .outValid  (outValid)
  );

  rvb_lpf #(.DATA_W(DATA_W), .TAPS(LPF_TAPS)) u_lpf (
    .clk   (clk),
    .rst   (rst),
    .start (ctl.filtStart),
    .din   (filtIn),
    .dout  (lpfOut),
    .done  (filtDone)
  );

endmodule

// File: rtl/rvb_checker.sv
module rvb_checker
  import rvb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LPF_TAPS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleIn,
  input logic              outValid,
  input logic [DATA_W-1:0] sampleOut,
  input logic              busy,
  input rvbCtl_t           ctl,
  input logic              filtDone
);

  localparam int BUSY_MAX = LPF_TAPS + 8;

  logic [15:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst)                       busyRun <= '0;
    else if (busy && busyRun != '1) busyRun <= busyRun + 1'b1;
    else if (!busy)                busyRun <= '0;
  end

  // R2: an output strobe is always caused by an input strobe one cycle earlier
  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(sampleValid));

  // R2: an update strobe produces no output
  a_r2_update_silent: assert property (@(posedge clk) disable iff (rst)
    ctl.latch |=> !outValid);

  // R8: strobes during the update chain are dropped
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (busy && sampleValid) |=> !outValid);

  // R7: the output sum never wraps below the live sample
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sampleOut >= $past(sampleIn)));

  // R5: the smoother reports completion only while the chain waits for it
  a_r5_done_in_chain: assert property (@(posedge clk) disable iff (rst)
    filtDone |-> busy);

  // R9: the update chain ends in bounded time
  a_r9_bounded_chain: assert property (@(posedge clk) disable iff (rst)
    busyRun <= 16'(BUSY_MAX));

endmodule

bind decim_reverb rvb_checker #(.DATA_W(DATA_W), .LPF_TAPS(LPF_TAPS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sampleValid (sampleValid),
  .sampleIn    (sampleIn),
  .outValid    (outValid),
  .sampleOut   (sampleOut),
  .busy        (busy),
  .ctl         (ctl),
  .filtDone    (filtDone)
);

// File: tb/sim_decim_reverb.sv
module sim_decim_reverb;

  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int DECIM = 4;
  localparam int TAPS  = 4;
  localparam int FB    = 819;
  localparam int OG    = 922;
  localparam int FRAC  = 10;
  localparam int GAP   = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sampleValid = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          outValid;
  logic [DW-1:0] sampleOut;

  always #5 clk = ~clk;

  decim_reverb #(
    .DATA_W(DW), .DEPTH(DEPTH), .DECIM(DECIM), .FB_GAIN(FB),
    .OUT_GAIN(OG), .GAIN_FRAC(FRAC), .LPF_TAPS(TAPS)
  ) u0 (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .outValid(outValid), .sampleOut(sampleOut)
  );

  typedef struct {
    int    val;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  // Reference model state, derived from the requirements
  int mMem[DEPTH];
  int mWr;
  int mCnt;
  int mHist[TAPS];
  int mLpf;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    for (int i = 0; i < TAPS; i++) mHist[i] = 0;
    mWr = 0; mCnt = 0; mLpf = 0;
  endtask

  // Driver: updates the model, pushes expectations, drives one strobe
  task automatic sendSample(input int v, input int gap);
    bit isUpd;
    isUpd = 0;
    if (mCnt == DECIM - 1) begin
      int tap, fb, fin, sum;
      isUpd = 1;
      mCnt = 0;
      mWr  = (mWr + 1) % DEPTH;                 // R3 offset advance with wrap
      tap  = mMem[(mWr + 1) % DEPTH];           // R3 oldest entry
      fb   = (tap * FB) >> FRAC;                // R4 feedback term
      mMem[mWr] = (v + fb > 255) ? 255 : v + fb;
      fin  = (tap * OG) >> FRAC;                // R5 smoother input
      for (int i = TAPS - 1; i > 0; i--) mHist[i] = mHist[i-1];
      mHist[0] = fin;
      sum = 0;
      for (int i = 0; i < TAPS; i++) sum += mHist[i];
      mLpf = sum / TAPS;
    end else begin
      expItem_t e;
      mCnt++;
      if (v + mLpf > 255) begin
        e.val = 255; e.tag = "R7 saturated output";
      end else begin
        e.val = v + mLpf;
        e.tag = (mLpf != 0) ? "R6 R5 R4 R3 echo output" : "R6 dry output";
      end
      expQ.push_back(e);
    end
    @(negedge clk);
    sampleIn    = DW'(v);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    if (isUpd) check(outValid == 1'b0, "R2 update strobe silent", int'(outValid), 0);
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: pops and compares each produced result
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", int'(sampleOut), -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(sampleOut == DW'(e.val), e.tag, int'(sampleOut), e.val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(sampleOut == '0, "R1 sampleOut after reset", int'(sampleOut), 0);

    // Ramp: fills the buffer, offset wraps (R3), echoes appear (R4 R5)
    for (int i = 0; i < 48; i++) sendSample((i * 6) % 256, GAP);

    // Loud constant: feedback builds up, output saturates (R7)
    for (int i = 0; i < 64; i++) sendSample(240, GAP);

    // R8: strobe inside the update chain is dropped
    while (mCnt != DECIM - 1) sendSample(17, GAP);
    sendSample(200, 0);
    @(negedge clk);
    sampleIn    = 8'd99;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check(outValid == 1'b0, "R8 busy strobe dropped", int'(outValid), 0);
    repeat (GAP) @(negedge clk);
    // following strobes must keep the original counting (R8 counter untouched)
    for (int i = 0; i < 12; i++) sendSample(10 + i, GAP);

    // Silence: only the decaying echo remains (R6)
    for (int i = 0; i < 40; i++) sendSample(0, GAP);

    // Pseudo-random pattern
    lfsr = 8'h5a;
    for (int i = 0; i < 80; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hff;
      sendSample(lfsr, GAP);
    end

    // R1: reset in mid-run clears buffer and smoother history
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all outputs produced before reset", expQ.size(), 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelReset();
    @(negedge clk);
    check(sampleOut == '0, "R1 sampleOut after mid-run reset", int'(sampleOut), 0);
    for (int i = 0; i < 24; i++) sendSample(30 + i, GAP);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 no missing outputs", expQ.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule